// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block is the segment table that sits in front of a 64-bit hashed address translator. It holds a parameterised number of segment entries (32 by default). Each entry pairs an effective segment identifier with a virtual segment word. An entry covers either a 256 MB segment or a 1 TB segment, so an effective address can be matched at either granularity. A combinational lookup port returns the matching entry for any effective address. When more than one entry matches, the lowest index is chosen.

Maintenance operations arrive one per cycle on a valid/ready request port. Each accepted operation is answered on the response port in the following cycle. The operations are:
- write an entry by slot, after legality checks;
- read back either half of an entry;
- invalidate every entry, steered by a hint code;
- invalidate the one entry that matches an address;
- find the segment word for an address.

Every invalidation that can leave stale translation state behind raises a one-cycle flush request toward the downstream translation cache, tagged local or global. A configuration input selects the newer architecture mode, which adds hint codes that preserve class-0 entries or clear nothing at all.

Top module: `slb_array`

## Requirements
- R1: A 256 MB entry (segment word bits [63:62] = 00) hits when it is valid and its stored identifier equals effective address bits [63:28]; an address in a different 256 MB segment misses, on both the lookup port and the request port.
- R2: A 1 TB entry (bits [63:62] = 01) hits when it is valid, its stored identifier bits [35:12] equal address bits [63:40] and its stored bits [11:0] are zero.
- R3: When several entries hit, the lowest index is reported (lk_idx, lk_vsid, find result); with no hit, lk_hit is 0.
- R4: Write (op 0) takes the slot from req_addr[11:0], the identifier from req_addr[63:28], the valid bit from req_addr[27] and the segment word from req_data; an entry written with bit 27 clear never hits.
- R5: A write is rejected with rsp_err=1 and changes nothing when any of these holds: the slot is not below NUM_ENTRIES; req_addr[26:12] is nonzero; req_data[63] is set; a 1 TB size is requested while cfg_1t_en=0; or the page-size field req_data[5:4] is not enabled in PAGE_LEGAL (default: 00, 01, 10 legal, 11 illegal).
- R6: Read-identifier (op 1) returns {identifier, valid, 27 zero bits} and read-word (op 2) returns the segment word; a slot not below NUM_ENTRIES gives rsp_err=1 with data 0. Op codes 6 and 7 also answer with rsp_err=1.
- R7: Invalidate-all (op 3) with hint 0, 1, 2 or 6, or with any hint when cfg_v3=0, clears the valid bit of every entry except entry 0.
- R8: With cfg_v3=1, hint 4 clears every entry including entry 0; hint 3 does the same but keeps entries whose class bit (segment word bit 7) is 0; hint 7 clears nothing.
- R9: With cfg_v3=1, hint 5 behaves as hint 0 and sets rsp_warn; rsp_warn is 0 for every other case.
- R10: Every invalidate-all raises flush_req with flush_global=0 in its response cycle.
- R11: Invalidate-one (op 4) clears the lowest entry that matches req_addr and raises flush_req, with flush_global equal to req_global; when nothing matches, no flush is raised and no entry changes. No other operation raises flush_req.
- R12: Find (op 5) returns the segment word of the matching entry, or all ones on a miss; with cfg_64bit=0 it answers rsp_err=1.
- R13: After reset, req_ready is 1 and rsp_valid, flush_req and lk_hit are 0. Every accepted request gives exactly one rsp_valid pulse in the next cycle, and rsp_valid stays 0 when no request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_v3 | input | 1 | Newer architecture mode (extra invalidate hints) |
| cfg_1t_en | input | 1 | 1 TB segments permitted |
| cfg_64bit | input | 1 | Machine is in 64-bit mode (find allowed) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 3 | Operation code |
| req_addr | input | 64 | Slot/identifier operand or effective address |
| req_data | input | 64 | Segment word for writes |
| req_hint | input | 3 | Invalidate-all hint |
| req_global | input | 1 | Invalidate-one flush scope (1 = global) |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 64 | Read or find result |
| rsp_err | output | 1 | Illegal-operation error |
| rsp_warn | output | 1 | Undefined hint was used |
| flush_req | output | 1 | Translation cache flush request |
| flush_global | output | 1 | Flush scope is global |
| lk_ea | input | 64 | Effective address for the lookup port |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_idx | output | IDX_W | Index of the matching entry |
| lk_vsid | output | 64 | Segment word of the matching entry |

## Verification
The hardest state to reach from the ports is a table in which several valid entries overlap in interesting ways. Two entries claim the same 256 MB segment, class-0 and class-1 entries coexist, and 1 TB and 256 MB entries sit in neighbouring address ranges. Only then can the priority and the class-preserving hint show their effect. The stimulus builds this state with sequences of legal writes, including duplicate identifiers that the write path does not forbid. Each invalidation is then observed through find requests and the lookup port, with the survivors checked against entries that should have gone. Rejected writes are confirmed by reading the targeted slot back unchanged.

// File: rtl/slb_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the segment lookaside buffer array.
// Assumes 64-bit effective addresses and 12-bit slot operands.
package slb_pkg;
    localparam int EA_W      = 64;
    localparam int SLOT_W    = 12;
    localparam int SEG_LSB   = 28;                 // 256 MB segment boundary
    localparam int TB_LSB    = 40;                 // 1 TB segment boundary
    localparam int VLD_BIT   = 27;                 // valid bit in identifier operand
    localparam int ESID_W    = EA_W - SEG_LSB;     // stored identifier width
    localparam int TB_PAD    = TB_LSB - SEG_LSB;   // identifier bits zero for 1 TB
    localparam int CLASS_BIT = 7;                  // class bit in segment word
    localparam int PG_LSB    = 4;                  // page-size field, 2 bits

    localparam logic [1:0] SZ_256M = 2'b00;
    localparam logic [1:0] SZ_1T   = 2'b01;

    typedef enum logic [2:0] {
        OP_WRITE   = 3'd0,
        OP_RD_ESID = 3'd1,
        OP_RD_VSID = 3'd2,
        OP_INV_ALL = 3'd3,
        OP_INV_ONE = 3'd4,
        OP_FIND    = 3'd5
    } slb_op_e;
endpackage

// File: rtl/slb_match.sv
`timescale 1ns/1ps
// Fully associative segment matcher with lowest-index priority.
// Compares a segment address against every entry at the size that entry
// declares. Purely combinational. Assumes stored identifiers of 1 TB
// entries carry zeros below the 1 TB boundary in order to match.
module slb_match
    import slb_pkg::*;
#(
    parameter int N     = 32,
    parameter int IDX_W = 5
) (
    input  logic [ESID_W-1:0]          seg_i,
    input  logic [N-1:0][ESID_W-1:0]   esid_i,
    input  logic [N-1:0]               vld_i,
    input  logic [N-1:0][1:0]          size_i,
    output logic                       hit_o,
    output logic [IDX_W-1:0]           idx_o
);
    logic [N-1:0] hv;

    // Per-entry hit at either segment size
    for (genvar k = 0; k < N; k++) begin : g_cmp
        logic m256;
        logic m1t;
        assign m256  = (size_i[k] == SZ_256M) && (esid_i[k] == seg_i);
        assign m1t   = (size_i[k] == SZ_1T) &&
                       (esid_i[k] == {seg_i[ESID_W-1:TB_PAD], {TB_PAD{1'b0}}});
        assign hv[k] = vld_i[k] && (m256 || m1t);
    end

    // Lowest set hit bit wins
    always_comb begin
        hit_o = |hv;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hv[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/slb_wr_check.sv
`timescale 1ns/1ps
// Legality check for an entry write: slot range, reserved operand bits,
// segment-size encoding, 1 TB permission and page-size encoding.
// Assumes PAGE_LEGAL bit n enables page-size code n.
module slb_wr_check
    import slb_pkg::*;
#(
    parameter int         N          = 32,
    parameter logic [3:0] PAGE_LEGAL = 4'b0111
) (
    input  logic [SLOT_W-1:0]          slot_i,
    input  logic [VLD_BIT-1:SLOT_W]    resv_i,
    input  logic [1:0]                 size_i,
    input  logic [1:0]                 page_i,
    input  logic                       en_1t_i,
    output logic                       bad_o
);
    logic bad_slot, bad_resv, bad_size, bad_page;

    // Each rejection reason on its own
    always_comb begin
        bad_slot = (slot_i >= SLOT_W'(N));
        bad_resv = |resv_i;
        bad_size = size_i[1] || (size_i[0] && !en_1t_i);
        bad_page = !PAGE_LEGAL[page_i];
        bad_o    = bad_slot || bad_resv || bad_size || bad_page;
    end
endmodule

// File: rtl/slb_inval_plan.sv
`timescale 1ns/1ps
// Turns an invalidate-all hint into a per-entry clear mask.
// Assumes the caller applies the mask only on an invalidate-all request.
module slb_inval_plan #(
    parameter int N = 32
) (
    input  logic [2:0]   hint_i,
    input  logic         v3_i,
    input  logic [N-1:0] cls_i,
    output logic [N-1:0] clr_o,
    output logic         warn_o
);
    logic from0, keep_c0, none;

    // Decode hint into start point, class filter and no-op
    always_comb begin
        from0   = 1'b0;
        keep_c0 = 1'b0;
        none    = 1'b0;
        warn_o  = 1'b0;
        if (v3_i) begin
            case (hint_i)
                3'd3:    begin from0 = 1'b1; keep_c0 = 1'b1; end
                3'd4:    from0  = 1'b1;
                3'd7:    none   = 1'b1;
                3'd5:    warn_o = 1'b1;
                default: ;
            endcase
        end
    end

    // Per-entry clear decision
    for (genvar k = 0; k < N; k++) begin : g_clr
        assign clr_o[k] = !none && ((k != 0) || from0) && !(keep_c0 && !cls_i[k]);
    end
endmodule

// File: rtl/slb_array.sv
`timescale 1ns/1ps
// Segment lookaside buffer array: entry storage, combinational lookup
// port, and a one-per-cycle maintenance port with registered response.
// Assumes requests are held only while req_valid is high; each accepted
// request is answered exactly one cycle later.
module slb_array
    import slb_pkg::*;
#(
    parameter int         NUM_ENTRIES = 32,
    parameter logic [3:0] PAGE_LEGAL  = 4'b0111,
    localparam int        IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_v3,
    input  logic              cfg_1t_en,
    input  logic              cfg_64bit,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [EA_W-1:0]   req_addr,
    input  logic [EA_W-1:0]   req_data,
    input  logic [2:0]        req_hint,
    input  logic              req_global,
    output logic              rsp_valid,
    output logic [EA_W-1:0]   rsp_data,
    output logic              rsp_err,
    output logic              rsp_warn,
    output logic              flush_req,
    output logic              flush_global,
    input  logic [EA_W-1:0]   lk_ea,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [EA_W-1:0]   lk_vsid
);
    localparam int N = NUM_ENTRIES;

    logic [N-1:0][ESID_W-1:0] esid_q;
    logic [N-1:0]             vld_q;
    logic [N-1:0][EA_W-1:0]   vsid_q;
    logic [N-1:0][1:0]        size_w;
    logic [N-1:0]             cls_w;

    slb_op_e           op;
    logic              acc;
    logic              slot_ok;
    logic [IDX_W-1:0]  sidx;
    logic              wr_bad;
    logic [N-1:0]      clr_mask;
    logic              inv_warn;
    logic              q_hit;
    logic [IDX_W-1:0]  q_idx;
    logic              lk_unused;

    logic [EA_W-1:0]   nx_data;
    logic              nx_err, nx_warn, nx_fl, nx_gl;

    assign op        = slb_op_e'(req_op);
    assign acc       = req_valid && req_ready;
    assign slot_ok   = req_addr[SLOT_W-1:0] < SLOT_W'(N);
    assign sidx      = req_addr[IDX_W-1:0];
    assign lk_unused = ^lk_ea[SEG_LSB-1:0];

    // Size and class fields of each stored segment word
    for (genvar k = 0; k < N; k++) begin : g_fields
        assign size_w[k] = vsid_q[k][EA_W-1:EA_W-2];
        assign cls_w[k]  = vsid_q[k][CLASS_BIT];
    end

    // Matcher for the lookup port
    slb_match #(.N(N), .IDX_W(IDX_W)) u_lk_match (
        .seg_i  (lk_ea[EA_W-1:SEG_LSB]),
        .esid_i (esid_q),
        .vld_i  (vld_q),
        .size_i (size_w),
        .hit_o  (lk_hit),
        .idx_o  (lk_idx)
    );

    // Matcher for invalidate-one and find requests
    slb_match #(.N(N), .IDX_W(IDX_W)) u_rq_match (
        .seg_i  (req_addr[EA_W-1:SEG_LSB]),
        .esid_i (esid_q),
        .vld_i  (vld_q),
        .size_i (size_w),
        .hit_o  (q_hit),
        .idx_o  (q_idx)
    );

    slb_wr_check #(.N(N), .PAGE_LEGAL(PAGE_LEGAL)) u_wr_check (
        .slot_i  (req_addr[SLOT_W-1:0]),
        .resv_i  (req_addr[VLD_BIT-1:SLOT_W]),
        .size_i  (req_data[EA_W-1:EA_W-2]),
        .page_i  (req_data[PG_LSB+1:PG_LSB]),
        .en_1t_i (cfg_1t_en),
        .bad_o   (wr_bad)
    );

    slb_inval_plan #(.N(N)) u_inval_plan (
        .hint_i (req_hint),
        .v3_i   (cfg_v3),
        .cls_i  (cls_w),
        .clr_o  (clr_mask),
        .warn_o (inv_warn)
    );

    assign lk_vsid = vsid_q[lk_idx];

    // Ready rises once reset is released
    always_ff @(posedge clk) begin
        if (!rst_n) req_ready <= 1'b0;
        else        req_ready <= 1'b1;
    end

    // Entry storage updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esid_q <= '0;
            vld_q  <= '0;
            vsid_q <= '0;
        end else if (acc) begin
            case (op)
                OP_WRITE: begin
                    if (!wr_bad) begin
                        esid_q[sidx] <= req_addr[EA_W-1:SEG_LSB];
                        vld_q[sidx]  <= req_addr[VLD_BIT];
                        vsid_q[sidx] <= req_data;
                    end
                end
                OP_INV_ALL: vld_q <= vld_q & ~clr_mask;
                OP_INV_ONE: begin
                    if (q_hit) vld_q[q_idx] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Response values for the current request
    always_comb begin
        nx_data = '0;
        nx_err  = 1'b0;
        nx_warn = 1'b0;
        nx_fl   = 1'b0;
        nx_gl   = 1'b0;
        case (op)
            OP_WRITE: nx_err = wr_bad;
            OP_RD_ESID: begin
                if (slot_ok) nx_data = {esid_q[sidx], vld_q[sidx], {VLD_BIT{1'b0}}};
                else         nx_err  = 1'b1;
            end
            OP_RD_VSID: begin
                if (slot_ok) nx_data = vsid_q[sidx];
                else         nx_err  = 1'b1;
            end
            OP_INV_ALL: begin
                nx_fl   = 1'b1;
                nx_warn = inv_warn;
            end
            OP_INV_ONE: begin
                nx_fl = q_hit;
                nx_gl = q_hit && req_global;
            end
            OP_FIND: begin
                if (!cfg_64bit)  nx_err  = 1'b1;
                else if (q_hit)  nx_data = vsid_q[q_idx];
                else             nx_data = '1;
            end
            default: nx_err = 1'b1;
        endcase
    end

    // Registered response and flush pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_data     <= '0;
            rsp_err      <= 1'b0;
            rsp_warn     <= 1'b0;
            flush_req    <= 1'b0;
            flush_global <= 1'b0;
        end else begin
            rsp_valid    <= acc;
            rsp_data     <= acc ? nx_data : '0;
            rsp_err      <= acc && nx_err;
            rsp_warn     <= acc && nx_warn;
            flush_req    <= acc && nx_fl;
            flush_global <= acc && nx_gl;
        end
    end
endmodule

// File: rtl/slb_array_chk.sv
`timescale 1ns/1ps
// Protocol and invariant checker for slb_array, attached by bind.
// Observes the request and response ports only.
module slb_array_chk
    import slb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_64bit,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_op,
    input logic [SLOT_W-1:0] req_slot,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              rsp_warn,
    input logic              flush_req
);
    logic acc;
    assign acc = req_valid && req_ready;

    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid); // R13
    AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid); // R13
    AST_INVALL_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == 3'(OP_INV_ALL)) |=> flush_req); // R10
    AST_FLUSH_ONLY_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && (req_op == 3'(OP_INV_ALL) || req_op == 3'(OP_INV_ONE))) |=> !flush_req); // R11
    AST_WRITE_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == 3'(OP_WRITE) && req_slot >= SLOT_W'(NUM_ENTRIES)) |=> rsp_err); // R5
    AST_FIND_NEEDS_64BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == 3'(OP_FIND) && !cfg_64bit) |=> rsp_err); // R12
    AST_WARN_ONLY_INVALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && req_op == 3'(OP_INV_ALL)) |=> !rsp_warn); // R9
endmodule

bind slb_array slb_array_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_slb_array_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_64bit (cfg_64bit),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_slot  (req_addr[11:0]),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_warn  (rsp_warn),
    .flush_req (flush_req)
);

// File: tb/slb_array_bench.sv
`timescale 1ns/1ps
// Self-checking bench for slb_array: a vector table walked in order,
// then directed tests for the lookup port, modes and corner cases.
module slb_array_bench;
    localparam int N = 32;
    localparam int IDX_W = 5;

    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] V0   = 64'h0000_0000_AAAA_0000;
    localparam logic [63:0] V1T  = 64'h4000_0000_BBBB_0000;
    localparam logic [63:0] VC1  = 64'h0000_0000_CCCC_0080;
    localparam logic [63:0] V2   = 64'h0000_0000_DDDD_0010;
    localparam logic [63:0] A0   = 64'h0000_0012_3800_0000;
    localparam logic [63:0] E123 = 64'h0000_0012_3000_0000;
    localparam logic [63:0] E1T  = 64'h0000_0200_0ABC_DEF0;
    localparam logic [63:0] EMIS = 64'h0000_0099_0000_0000;

    typedef struct packed {
        logic [7:0]  rq;
        logic [2:0]  op;
        logic [63:0] addr;
        logic [63:0] data;
        logic [2:0]  hint;
        logic        glob;
        logic [63:0] exp_data;
        logic        exp_err;
        logic        exp_fl;
        logic        exp_gl;
        logic        exp_wn;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VECS [NV] = '{
        '{8'd4,  3'd0, A0,                     V0,  3'd0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4
        '{8'd6,  3'd1, 64'd0,                  0,   3'd0, 1'b0, A0,    1'b0, 1'b0, 1'b0, 1'b0}, // R6
        '{8'd6,  3'd2, 64'd0,                  0,   3'd0, 1'b0, V0,    1'b0, 1'b0, 1'b0, 1'b0}, // R6
        '{8'd2,  3'd0, 64'h0000_0200_0800_0005, V1T, 3'd0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
        '{8'd2,  3'd5, E1T,                    0,   3'd0, 1'b0, V1T,   1'b0, 1'b0, 1'b0, 1'b0}, // R2
        '{8'd1,  3'd5, 64'h0000_0012_3456_7890, 0,   3'd0, 1'b0, V0,    1'b0, 1'b0, 1'b0, 1'b0}, // R1
        '{8'd12, 3'd5, EMIS,                   0,   3'd0, 1'b0, ONES,  1'b0, 1'b0, 1'b0, 1'b0}, // R12
        '{8'd5,  3'd0, 64'h0000_0012_3800_0020, V0,  3'd0, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5
        '{8'd5,  3'd0, 64'h0000_0012_3800_1003, V0,  3'd0, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5
        '{8'd5,  3'd0, 64'h0000_0012_3800_0003, 64'h8000_0000_0000_0000, 3'd0, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5
        '{8'd5,  3'd0, 64'h0000_0012_3800_0003, 64'h0000_0000_0000_0030, 3'd0, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5
        '{8'd5,  3'd2, 64'd3,                  0,   3'd0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5
        '{8'd6,  3'd1, 64'd40,                 0,   3'd0, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R6
        '{8'd3,  3'd0, 64'h0000_0012_3800_0007, VC1, 3'd0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
        '{8'd3,  3'd5, E123,                   0,   3'd0, 1'b0, V0,    1'b0, 1'b0, 1'b0, 1'b0}, // R3
        '{8'd11, 3'd4, E123,                   0,   3'd0, 1'b1, 64'd0, 1'b0, 1'b1, 1'b1, 1'b0}, // R11
        '{8'd11, 3'd5, E123,                   0,   3'd0, 1'b0, VC1,   1'b0, 1'b0, 1'b0, 1'b0}, // R11
        '{8'd11, 3'd4, EMIS,                   0,   3'd0, 1'b1, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R11
        '{8'd8,  3'd3, 64'd0,                  0,   3'd3, 1'b0, 64'd0, 1'b0, 1'b1, 1'b0, 1'b0}, // R8
        '{8'd8,  3'd5, E1T,                    0,   3'd0, 1'b0, V1T,   1'b0, 1'b0, 1'b0, 1'b0}, // R8
        '{8'd8,  3'd5, E123,                   0,   3'd0, 1'b0, ONES,  1'b0, 1'b0, 1'b0, 1'b0}, // R8
        '{8'd7,  3'd0, A0,                     V0,  3'd0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7
        '{8'd10, 3'd3, 64'd0,                  0,   3'd6, 1'b1, 64'd0, 1'b0, 1'b1, 1'b0, 1'b0}, // R10
        '{8'd7,  3'd5, E123,                   0,   3'd0, 1'b0, V0,    1'b0, 1'b0, 1'b0, 1'b0}, // R7
        '{8'd7,  3'd5, E1T,                    0,   3'd0, 1'b0, ONES,  1'b0, 1'b0, 1'b0, 1'b0}, // R7
        '{8'd8,  3'd3, 64'd0,                  0,   3'd7, 1'b0, 64'd0, 1'b0, 1'b1, 1'b0, 1'b0}, // R8
        '{8'd8,  3'd5, E123,                   0,   3'd0, 1'b0, V0,    1'b0, 1'b0, 1'b0, 1'b0}, // R8
        '{8'd8,  3'd3, 64'd0,                  0,   3'd4, 1'b0, 64'd0, 1'b0, 1'b1, 1'b0, 1'b0}, // R8
        '{8'd8,  3'd5, E123,                   0,   3'd0, 1'b0, ONES,  1'b0, 1'b0, 1'b0, 1'b0}, // R8
        '{8'd9,  3'd0, A0,                     V0,  3'd0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R9
        '{8'd9,  3'd0, 64'h0000_0055_0800_0002, V2,  3'd0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R9
        '{8'd9,  3'd3, 64'd0,                  0,   3'd5, 1'b0, 64'd0, 1'b0, 1'b1, 1'b0, 1'b1}, // R9
        '{8'd9,  3'd5, E123,                   0,   3'd0, 1'b0, V0,    1'b0, 1'b0, 1'b0, 1'b0}, // R9
        '{8'd9,  3'd5, 64'h0000_0055_0000_0000, 0,   3'd0, 1'b0, ONES,  1'b0, 1'b0, 1'b0, 1'b0}  // R9
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_v3 = 1'b1, cfg_1t_en = 1'b1, cfg_64bit = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [2:0]        req_op = '0;
    logic [63:0]       req_addr = '0, req_data = '0;
    logic [2:0]        req_hint = '0;
    logic              req_global = 1'b0;
    logic              rsp_valid, rsp_err, rsp_warn, flush_req, flush_global;
    logic [63:0]       rsp_data;
    logic [63:0]       lk_ea = '0;
    logic              lk_hit;
    logic [IDX_W-1:0]  lk_idx;
    logic [63:0]       lk_vsid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    slb_array #(.NUM_ENTRIES(N)) u_slb_array (
        .clk(clk), .rst_n(rst_n), .cfg_v3(cfg_v3), .cfg_1t_en(cfg_1t_en),
        .cfg_64bit(cfg_64bit), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .req_hint(req_hint), .req_global(req_global), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_err(rsp_err), .rsp_warn(rsp_warn),
        .flush_req(flush_req), .flush_global(flush_global), .lk_ea(lk_ea),
        .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_vsid(lk_vsid)
    );

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Drive one request for one cycle; outputs are sampled at the next falling edge
    task automatic do_op(input logic [2:0] op, input logic [63:0] a, input logic [63:0] d,
                         input logic [2:0] h, input logic g);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        req_hint = h; req_global = g;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic look(input logic [63:0] ea);
        lk_ea = ea;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R13 reset state
        chk("R13 ready", 64'(req_ready), 64'd1);
        chk("R13 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R13 flush", 64'(flush_req), 64'd0);
        look(E123);
        chk("R13 lk_hit", 64'(lk_hit), 64'd0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d row%0d", VECS[i].rq, i);
            do_op(VECS[i].op, VECS[i].addr, VECS[i].data, VECS[i].hint, VECS[i].glob);
            chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
            chk({tag, " data"},  rsp_data, VECS[i].exp_data);
            chk({tag, " err"},   64'(rsp_err), 64'(VECS[i].exp_err));
            chk({tag, " flush"}, 64'(flush_req), 64'(VECS[i].exp_fl));
            chk({tag, " glob"},  64'(flush_global), 64'(VECS[i].exp_gl));
            chk({tag, " warn"},  64'(rsp_warn), 64'(VECS[i].exp_wn));
        end

        // R13: no response when no request was accepted
        @(negedge clk);
        chk("R13 idle rsp_valid", 64'(rsp_valid), 64'd0);

        // R3 / R2 / R1 on the lookup port
        do_op(3'd0, 64'h0000_0077_0800_0004, V2,  3'd0, 1'b0);
        do_op(3'd0, 64'h0000_0077_0800_0009, VC1, 3'd0, 1'b0);
        do_op(3'd0, 64'h0000_0300_0800_0001, V1T, 3'd0, 1'b0);
        do_op(3'd0, 64'h0000_0400_0800_000A, V0,  3'd0, 1'b0);
        look(64'h0000_0077_0000_1234);
        chk("R3 lk_hit", 64'(lk_hit), 64'd1);
        chk("R3 lk_idx", 64'(lk_idx), 64'd4);
        chk("R3 lk_vsid", lk_vsid, V2);
        look(64'h0000_0300_1234_5678);
        chk("R2 lk_idx", 64'(lk_idx), 64'd1);
        chk("R2 lk_vsid", lk_vsid, V1T);
        look(64'h0000_0400_1000_0000);
        chk("R1 lk neighbour miss", 64'(lk_hit), 64'd0);
        look(64'h0000_0400_0FFF_FFFF);
        chk("R1 lk_idx", 64'(lk_idx), 64'd10);

        // R4: entry written with valid bit clear
        do_op(3'd0, 64'h0000_0066_0000_0003, V0, 3'd0, 1'b0);
        chk("R4 write ok", 64'(rsp_err), 64'd0);
        look(64'h0000_0066_0000_0000);
        chk("R4 invalid no hit", 64'(lk_hit), 64'd0);
        do_op(3'd1, 64'd3, 64'd0, 3'd0, 1'b0);
        chk("R4 readback", rsp_data, 64'h0000_0066_0000_0000);

        // R5: 1 TB while disabled
        cfg_1t_en = 1'b0;
        do_op(3'd0, 64'h0000_0500_0800_0006, V1T, 3'd0, 1'b0);
        chk("R5 1T disabled err", 64'(rsp_err), 64'd1);
        cfg_1t_en = 1'b1;
        do_op(3'd2, 64'd6, 64'd0, 3'd0, 1'b0);
        chk("R5 slot unchanged", rsp_data, 64'd0);

        // R6: undefined op code
        do_op(3'd6, 64'd0, 64'd0, 3'd0, 1'b0);
        chk("R6 undefined op err", 64'(rsp_err), 64'd1);

        // R12: find outside 64-bit mode
        cfg_64bit = 1'b0;
        do_op(3'd5, E123, 64'd0, 3'd0, 1'b0);
        chk("R12 not 64-bit err", 64'(rsp_err), 64'd1);
        cfg_64bit = 1'b1;

        // R7 / R9: legacy mode hints
        cfg_v3 = 1'b0;
        do_op(3'd3, 64'd0, 64'd0, 3'd3, 1'b0);
        chk("R7 legacy flush", 64'(flush_req), 64'd1);
        chk("R9 legacy no warn", 64'(rsp_warn), 64'd0);
        look(64'h0000_0077_0000_0000);
        chk("R7 legacy cleared", 64'(lk_hit), 64'd0);
        look(E123);
        chk("R7 legacy entry0 kept", 64'(lk_hit), 64'd1);
        do_op(3'd3, 64'd0, 64'd0, 3'd5, 1'b0);
        chk("R9 legacy hint5 no warn", 64'(rsp_warn), 64'd0);
        cfg_v3 = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule